// File: doc/BRIEF.md
# Conditional-Move Condition Evaluator

This block decides whether a conditional floating-point register move takes effect. A request names a condition source and a condition code. The source is one of three kinds. The first is a 2-bit floating-point comparison result, taken from one of four fields of the FP status word. The second is an integer flag nibble holding negative, zero, overflow and carry, in its 32-bit or 64-bit flavour. The third is a 64-bit integer register value that is compared against zero. The single result bit is the move-enable.

All three kinds share one scheme. The low bits of the condition code pick a test, and one higher bit inverts the outcome of that test. For the floating-point source, the unordered comparison outcome is a full fourth value that tests can match. Fetching the register value and carrying out the move are handled outside the block.

Requests enter on a valid/ready handshake and results leave on a second one. By default one register stage sits between them. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result that has been presented stays unchanged until `res_ready` takes it. With `REGISTERED` set to 0, the path is combinational: valid and ready pass straight through.

Top module: `cmove_cond_eval`

## Requirements
- R1: `src_kind` selects the source: 0 = FP condition code, 1 = integer flags, 2 = register against zero, 3 = no source, in which case move-enable is always 0.
- R2: The FP code is 0 = equal, 1 = less, 2 = greater, 3 = unordered. `cc_sel` picks it from `fp_status`: 0 takes bits 11:10, 1 takes bits 33:32, 2 takes bits 35:34 and 3 takes bits 37:36.
- R3: For the FP source, `cond[2:0]` selects the test as follows: 0 never, 1 code≠0, 2 code is 1 or 2, 3 code bit 0 set, 4 code==1, 5 code bit 1 set, 6 code==2, 7 code==3.
- R4: For the integer source, `cc_sel[0]`=0 takes `int_flags[3:0]` and `cc_sel[0]`=1 takes `int_flags[7:4]`. Within the nibble the order is N,Z,V,C from bit 3 down to bit 0.
- R5: For the integer source, `cond[2:0]` selects the test as follows: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 Z or C, 5 C, 6 N, 7 V.
- R6: For the FP and integer sources, `cond[3]` inverts the test result. A code of 0 therefore never moves and a code of 8 always moves.
- R7: For the register source, `cond[1:0]` selects the test: 0 never, 1 value==0, 2 signed value≤0, 3 signed value<0. `cond[2]` inverts the test, and `cond[3]` has no effect.
- R8: When `reg_idx` is 0, the register operand is treated as zero whatever `reg_value` holds.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `move_en` keeps its value. `req_ready` equals `!res_valid || res_ready`.
- R10: An accepted request yields its result with `res_valid` high on the next cycle. Results leave in acceptance order. After reset, `res_valid` and `move_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| src_kind | input | 2 | Condition source kind |
| cond | input | 4 | Condition code with inversion bit |
| cc_sel | input | 2 | FP field select / integer width select |
| fp_status | input | 64 | FP status word |
| int_flags | input | 8 | Integer flags, 64-bit nibble high |
| reg_idx | input | 5 | Index of the register operand |
| reg_value | input | 64 | Register operand value |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| move_en | output | 1 | Move takes effect |

## Verification
Two things can happen in the same cycle: a stalled result is held, and a new request is accepted as that result drains. The consumer's ready is driven from a pseudo-random pattern while requests are offered back to back, so stalls, drain-and-refill edges and idle gaps all occur. A scoreboard judges each result against a model built from the condition tables. Every stalled cycle is also checked for an unchanged result.

// File: rtl/cmove_pkg.sv
package cmove_pkg;
  typedef enum logic [1:0] {
    SRC_FCC  = 2'd0,
    SRC_ICC  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_NONE = 2'd3
  } cmove_src_e;

  localparam int FCC_W     = 2;
  localparam int FCC_COUNT = 4;
  localparam int NIB_W     = 4;

  // Low bit of FP comparison field i inside the status word
  function automatic int fcc_lsb(input int i);
    return (i == 0) ? 10 : 30 + 2 * i;
  endfunction
endpackage

// File: rtl/cmove_fcc_eval.sv
module cmove_fcc_eval
  import cmove_pkg::*;
#(
  parameter int STATUS_W = 64
) (
  input  logic [STATUS_W-1:0] status,
  input  logic [1:0]          sel,
  input  logic [2:0]          test,
  output logic                hit
);
  logic [FCC_W-1:0] field [FCC_COUNT];
  logic [FCC_W-1:0] code;

  for (genvar g = 0; g < FCC_COUNT; g++) begin : g_field
    assign field[g] = status[fcc_lsb(g) +: FCC_W];
  end

  assign code = field[sel];

  always_comb begin
    unique case (test)
      3'd0: hit = 1'b0;
      3'd1: hit = (code != 2'd0);
      3'd2: hit = (code == 2'd1) || (code == 2'd2);
      3'd3: hit = code[0];
      3'd4: hit = (code == 2'd1);
      3'd5: hit = code[1];
      3'd6: hit = (code == 2'd2);
      default: hit = (code == 2'd3);
    endcase
  end
endmodule

// File: rtl/cmove_icc_eval.sv
module cmove_icc_eval
  import cmove_pkg::*;
#(
  parameter int FLAGS_W = 8
) (
  input  logic [FLAGS_W-1:0] flags,
  input  logic               wide,
  input  logic [2:0]         test,
  output logic               hit
);
  localparam int NIBS = FLAGS_W / NIB_W;

  logic [NIB_W-1:0] nib_arr [NIBS];
  logic [NIB_W-1:0] nib;
  logic n_f, z_f, v_f, c_f;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib_arr[g] = flags[g*NIB_W +: NIB_W];
  end

  assign nib = wide ? nib_arr[NIBS-1] : nib_arr[0];
  assign {n_f, z_f, v_f, c_f} = nib;

  always_comb begin
    unique case (test)
      3'd0: hit = 1'b0;
      3'd1: hit = z_f;
      3'd2: hit = z_f | (n_f ^ v_f);
      3'd3: hit = n_f ^ v_f;
      3'd4: hit = z_f | c_f;
      3'd5: hit = c_f;
      3'd6: hit = n_f;
      default: hit = v_f;
    endcase
  end
endmodule

// File: rtl/cmove_reg_eval.sv
module cmove_reg_eval #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] value,
  input  logic [1:0]        test,
  output logic              hit
);
  logic [DATA_W-1:0] opnd;
  logic              is_zero, is_neg;

  assign opnd    = (idx == '0) ? '0 : value;
  assign is_zero = (opnd == '0);
  assign is_neg  = opnd[DATA_W-1];

  always_comb begin
    unique case (test)
      2'd0: hit = 1'b0;
      2'd1: hit = is_zero;
      2'd2: hit = is_zero | is_neg;
      default: hit = is_neg;
    endcase
  end
endmodule

// File: rtl/cmove_cond_eval.sv
module cmove_cond_eval
  import cmove_pkg::*;
#(
  parameter int  STATUS_W   = 64,
  parameter int  FLAGS_W    = 8,
  parameter int  DATA_W     = 64,
  parameter int  IDX_W      = 5,
  parameter bit  REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          src_kind,
  input  logic [3:0]          cond,
  input  logic [1:0]          cc_sel,
  input  logic [STATUS_W-1:0] fp_status,
  input  logic [FLAGS_W-1:0]  int_flags,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [DATA_W-1:0]   reg_value,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                move_en
);
  logic hit_fcc, hit_icc, hit_reg, decision;
  cmove_src_e kind;

  assign kind = cmove_src_e'(src_kind);

  cmove_fcc_eval #(.STATUS_W(STATUS_W)) u_fcc (
    .status(fp_status), .sel(cc_sel), .test(cond[2:0]), .hit(hit_fcc)
  );

  cmove_icc_eval #(.FLAGS_W(FLAGS_W)) u_icc (
    .flags(int_flags), .wide(cc_sel[0]), .test(cond[2:0]), .hit(hit_icc)
  );

  cmove_reg_eval #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_reg (
    .idx(reg_idx), .value(reg_value), .test(cond[1:0]), .hit(hit_reg)
  );

  always_comb begin
    unique case (kind)
      SRC_FCC: decision = hit_fcc ^ cond[3];
      SRC_ICC: decision = hit_icc ^ cond[3];
      SRC_REG: decision = hit_reg ^ cond[2];
      default: decision = 1'b0;
    endcase
  end

  if (REGISTERED) begin : g_reg
    logic vld_q, en_q;

    assign req_ready = !vld_q || res_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        en_q  <= 1'b0;
      end else if (req_ready) begin
        vld_q <= req_valid;
        if (req_valid) en_q <= decision;
      end
    end

    assign res_valid = vld_q;
    assign move_en   = en_q;

    // R9: a stalled result is held unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ready |=> res_valid && $stable(move_en));

    // R10: an accepted request appears on the next cycle
    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> res_valid);

    // R6: code 0 never moves, for any source kind
    a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && cond == 4'b0000 |=> !move_en);

    // R6: code 8 always moves for the FP and integer sources
    a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && cond == 4'b1000 &&
      (src_kind == 2'd0 || src_kind == 2'd1) |=> move_en);

    // R8: register 0 satisfies the zero test whatever its value
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && src_kind == 2'd2 && reg_idx == '0 &&
      cond[2:0] == 3'b001 |=> move_en);

    // R1: no-source requests never enable a move
    a_r1_none: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && src_kind == 2'd3 |=> !move_en);
  end else begin : g_comb
    assign req_ready = res_ready;
    assign res_valid = req_valid;
    assign move_en   = req_valid & decision;
  end
endmodule

// File: tb/test_cmove_cond_eval.sv
module test_cmove_cond_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  src_kind = '0;
  logic [3:0]  cond = '0;
  logic [1:0]  cc_sel = '0;
  logic [63:0] fp_status = '0;
  logic [7:0]  int_flags = '0;
  logic [4:0]  reg_idx = '0;
  logic [63:0] reg_value = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        move_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit held = 0;
  logic held_val = 1'b0;

  always #2.5 clk = ~clk;

  cmove_cond_eval i_cmove_cond_eval (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_kind(src_kind), .cond(cond), .cc_sel(cc_sel), .fp_status(fp_status),
    .int_flags(int_flags), .reg_idx(reg_idx), .reg_value(reg_value),
    .res_valid(res_valid), .res_ready(res_ready), .move_en(move_en)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit model(input logic [1:0] k, input logic [3:0] c, input logic [1:0] s,
                               input logic [63:0] st, input logic [7:0] fl,
                               input logic [4:0] ix, input logic [63:0] v);
    bit r;
    logic [1:0] f;
    logic [3:0] nb;
    logic signed [63:0] sv;
    r = 0;
    case (k)
      2'd0: begin  // R2 R3
        case (s)
          2'd0: f = st[11:10];
          2'd1: f = st[33:32];
          2'd2: f = st[35:34];
          default: f = st[37:36];
        endcase
        case (c[2:0])
          3'd1: r = f != 0;
          3'd2: r = f == 1 || f == 2;
          3'd3: r = f == 1 || f == 3;
          3'd4: r = f == 1;
          3'd5: r = f == 2 || f == 3;
          3'd6: r = f == 2;
          3'd7: r = f == 3;
          default: r = 0;
        endcase
        r = r ^ c[3];  // R6
      end
      2'd1: begin  // R4 R5
        nb = s[0] ? fl[7:4] : fl[3:0];
        case (c[2:0])
          3'd1: r = nb[2];
          3'd2: r = nb[2] || (nb[3] != nb[1]);
          3'd3: r = nb[3] != nb[1];
          3'd4: r = nb[2] || nb[0];
          3'd5: r = nb[0];
          3'd6: r = nb[3];
          3'd7: r = nb[1];
          default: r = 0;
        endcase
        r = r ^ c[3];
      end
      2'd2: begin  // R7 R8
        sv = (ix == 0) ? 64'sd0 : $signed(v);
        case (c[1:0])
          2'd1: r = sv == 0;
          2'd2: r = sv <= 0;
          2'd3: r = sv < 0;
          default: r = 0;
        endcase
        r = r ^ c[2];
      end
      default: r = 0;  // R1
    endcase
    return r;
  endfunction

  task automatic send(input logic [1:0] k, input logic [3:0] c, input logic [1:0] s,
                      input logic [63:0] st, input logic [7:0] fl,
                      input logic [4:0] ix, input logic [63:0] v, input string tag);
    @(negedge clk);
    src_kind = k; cond = c; cc_sel = s; fp_status = st;
    int_flags = fl; reg_idx = ix; reg_value = v; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(k, c, s, st, fl, ix, v));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // Monitor: picks consumer ready, compares delivered results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (held && res_valid) check(move_en === held_val, "R9 hold", move_en, held_val);
      else if (held) check(1'b0, "R9 valid dropped", res_valid, 1'b1);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = (lfsr[1:0] != 2'b00);
      held = res_valid && !res_ready;
      held_val = move_en;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected result", move_en, 1'bx);
        else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(move_en === e, t, move_en, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(res_valid === 1'b0, "R10 reset valid", res_valid, 1'b0);
    check(move_en === 1'b0, "R10 reset move_en", move_en, 1'b0);
    check(req_ready === 1'b1, "R9 reset ready", req_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // FP source: every field, code and condition (R2 R3 R6)
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++)
        for (int c = 0; c < 16; c++) begin
          logic [63:0] st;
          st = 64'hFFFF_FFC0_FFFF_F3FF ^ 64'h0000_003F_0000_0C00;  // other fields busy
          st = 64'hAAAA_AAAA_AAAA_AAAA;
          case (s)
            0: st[11:10] = 2'(f);
            1: st[33:32] = 2'(f);
            2: st[35:34] = 2'(f);
            default: st[37:36] = 2'(f);
          endcase
          // make the other fields differ from the chosen one
          if (s != 0) st[11:10] = ~2'(f);
          if (s != 1) st[33:32] = ~2'(f);
          if (s != 2) st[35:34] = ~2'(f);
          if (s != 3) st[37:36] = ~2'(f);
          send(2'd0, 4'(c), 2'(s), st, 8'h00, 5'd0, 64'd0, "R3 fp cond");
        end

    // Integer source: both widths, all flags, all conditions (R4 R5 R6)
    for (int w = 0; w < 2; w++)
      for (int fl = 0; fl < 16; fl++)
        for (int c = 0; c < 16; c++) begin
          logic [7:0] fb;
          fb = w ? {4'(fl), ~4'(fl)} : {~4'(fl), 4'(fl)};
          send(2'd1, 4'(c), 2'(w) | 2'b10, 64'd0, fb, 5'd0, 64'd0, "R5 int cond");
        end

    // Register source: values, conditions, cond[3] ignored (R7)
    for (int vi = 0; vi < 5; vi++)
      for (int c = 0; c < 16; c++) begin
        logic [63:0] v;
        case (vi)
          0: v = 64'd0;
          1: v = 64'd1;
          2: v = 64'hFFFF_FFFF_FFFF_FFFF;
          3: v = 64'h8000_0000_0000_0000;
          default: v = 64'h7FFF_FFFF_FFFF_FFFF;
        endcase
        send(2'd2, 4'(c), 2'd0, 64'd0, 8'h00, 5'd7, v, "R7 reg cond");
      end

    // Register 0 reads as zero despite a nonzero value (R8)
    for (int c = 0; c < 8; c++)
      send(2'd2, 4'(c), 2'd0, 64'd0, 8'h00, 5'd0, 64'h8000_0000_0000_0005, "R8 reg zero");

    // No-source kind never moves (R1)
    for (int c = 0; c < 16; c++)
      send(2'd3, 4'(c), 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 5'd3, 64'd0, "R1 none");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    done = 1;
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 results lost actual=%0d expected=0", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule